// File: doc/BRIEF.md
# Per-Channel Saturation Monitor

This block watches every channel of a multi-channel sigma-delta conversion path at three taps. The first tap is the one-bit modulator stream, the second is the decimation filter result and the third is the word after gain and offset correction. Each tap has its own detector. A stuck modulator is found by counting identical bits. A filter overrange is found by comparing the result against a limit about 20% beyond full scale. An output clip is found when the corrected word sits on either rail code.

Every detector drives a sticky flag. The flags of two neighbouring channels are packed into one 8-bit status byte. A read strobe for a byte clears its flags, but only where the condition behind a flag has gone away. Three shared disable inputs switch off one detector type each. With all three tied low, every detector is active.

Top module: `sat_monitor`

## Requirements
- R1: After reset every bit of every status byte is 0, and each run counter is empty.
- R2: A channel's modulator flag sets after RUN_LEN (default 20) consecutive identical bits have been sampled with the bit strobe high. The bits may be all ones or all zeros. After RUN_LEN-1 such bits the flag stays clear. Bit values presented while the strobe is low are ignored.
- R3: The run count restarts at one when a sampled bit differs from the previous sampled bit, and it holds at RUN_LEN while the run continues.
- R4: A channel's filter flag sets when a sampled filter word, read as two's complement, is greater than LIM or less than -LIM. LIM = FS + FS*819/4096, where FS is the filter full-scale parameter (default 2^23) and 819/4096 is 0.2 truncated to 12 binary places. A word equal to LIM or -LIM does not set the flag.
- R5: A channel's output flag sets when a sampled output word equals the most positive code (0 followed by ones) or the most negative code (1 followed by zeros) of OUT_W bits. All other codes do not set it.
- R6: Status byte p covers channels 2p and 2p+1. Bit 0 is the output flag, bit 1 the filter flag and bit 2 the modulator flag of channel 2p. Bits 3, 4 and 5 hold the same three flags of channel 2p+1. Bits 7 and 6 always read 0.
- R7: det_dis bit 0 disables the output detectors, bit 1 the filter detectors and bit 2 the modulator detectors. While its bit is 1, no flag of that type sets. When the bit returns to 0 and the condition is still present, the flag sets.
- R8: A set flag stays set when its condition goes away, until its byte is read.
- R9: A read strobe for byte p leaves a flag set if its condition is still present. For the modulator this means the run is still at RUN_LEN. For filter and output it means the most recent sample was out of bounds. Otherwise the flag clears.
- R10: A flag becomes visible after the first rising clock edge that samples its triggering strobe, and a read strobe for one byte leaves all other bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | NUM_CH | Modulator bit per channel |
| mod_vld | input | NUM_CH | Modulator bit strobe per channel |
| filt_data | input | NUM_CH*FILT_W | Signed filter word per channel, channel 0 in the low bits |
| filt_vld | input | NUM_CH | Filter word strobe per channel |
| out_data | input | NUM_CH*OUT_W | Signed corrected output word per channel, channel 0 in the low bits |
| out_vld | input | NUM_CH | Output word strobe per channel |
| det_dis | input | 3 | Detector type disables: [0] output, [1] filter, [2] modulator |
| rd_strobe | input | NUM_CH/2 | Read strobe per status byte |
| pair_regs | output | NUM_CH/2*8 | Packed status bytes, byte 0 in the low bits |

## Verification
The bench aims at four corner areas.

- Run length: it sweeps every run length from one to one past the terminal count, for both bit polarities on every channel, with ignored bits mixed in. A counter that is off by one, that counts bits sampled with the strobe low, or that forgets to restart on a bit change would flag at the wrong length.
- Filter limit: the threshold is hit at exactly LIM and at LIM plus one on both sides, so a swapped comparison or a wrong shift series shows up as a missing or extra flag.
- Output rails: the rail codes and their nearest neighbours are probed.
- Flag handling: reads are issued while a condition is still present and after it has gone, and detectors are disabled and re-enabled with a condition active. A flag that clears too eagerly, ignores its disable bit or lands in the wrong slot of the byte is caught.

// File: rtl/sat_pkg.sv
`timescale 1ns/1ps
package sat_pkg;

  // Which comparison a level detector applies to its sampled word
  typedef enum logic [0:0] {
    KIND_CLIP  = 1'b0,   // word sits on a rail code
    KIND_RANGE = 1'b1    // word beyond the overrange limit
  } level_kind_e;

  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned SLOT_BITS = 3;
  // slot order inside one channel's 3-bit group
  localparam int unsigned SLOT_OUT  = 0;
  localparam int unsigned SLOT_FILT = 1;
  localparam int unsigned SLOT_MOD  = 2;
  // det_dis bit positions
  localparam int unsigned DIS_OUT   = 0;
  localparam int unsigned DIS_FILT  = 1;
  localparam int unsigned DIS_MOD   = 2;

  // 0.2 * fs from shifts: 1/8+1/16+1/128+1/256+1/2048+1/4096
  function automatic longint unsigned fifth_of(input longint unsigned fs);
    return (fs >> 3) + (fs >> 4) + (fs >> 7) + (fs >> 8) + (fs >> 11) + (fs >> 12);
  endfunction

  // overrange limit: full scale plus about one fifth
  function automatic longint unsigned range_limit(input longint unsigned fs);
    return fs + fifth_of(fs);
  endfunction

endpackage

// File: rtl/sat_run_det.sv
`timescale 1ns/1ps
module sat_run_det #(
  parameter int unsigned RUN_LEN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  logic bit_i,
  output logic live_q_o,
  output logic live_d_o
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] TERM = CW'(RUN_LEN);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          prev_q;
  logic          same_bit;

  assign same_bit = (cnt_q != '0) && (bit_i == prev_q);

  always_comb begin
    cnt_d = cnt_q;
    if (vld_i) begin
      if (same_bit) begin
        cnt_d = (cnt_q == TERM) ? TERM : cnt_q + ONE;
      end else begin
        cnt_d = ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (vld_i) begin
        prev_q <= bit_i;
      end
    end
  end

  assign live_q_o = (cnt_q == TERM);
  assign live_d_o = (cnt_d == TERM);

endmodule

// File: rtl/sat_level_det.sv
`timescale 1ns/1ps
module sat_level_det
  import sat_pkg::*;
#(
  parameter int unsigned     W    = 24,
  parameter level_kind_e     KIND = KIND_CLIP,
  parameter longint unsigned FS   = 64'd8388608
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  output logic         live_q_o,
  output logic         live_d_o
);
  logic over;
  logic live_q;

  generate
    if (KIND == KIND_RANGE) begin : g_range
      localparam logic signed [W:0] LIM = $signed((W+1)'(range_limit(FS)));
      logic signed [W:0] d_ext;
      assign d_ext = $signed({data_i[W-1], data_i});
      assign over  = (d_ext > LIM) || (d_ext < -LIM);
    end else begin : g_clip
      localparam logic [W-1:0] TOP_CODE = {1'b0, {(W-1){1'b1}}};
      localparam logic [W-1:0] BOT_CODE = {1'b1, {(W-1){1'b0}}};
      assign over = (data_i == TOP_CODE) || (data_i == BOT_CODE);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else if (vld_i) begin
      live_q <= over;
    end
  end

  assign live_q_o = live_q;
  assign live_d_o = vld_i ? over : live_q;

endmodule

// File: rtl/sat_sticky.sv
`timescale 1ns/1ps
module sat_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic rd_i,
  input  logic live_d_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  // read drops the flag, a live condition re-asserts it in the same cycle
  assign flag_d = (rd_i ? 1'b0 : flag_q) | (en_i & live_d_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/sat_monitor.sv
`timescale 1ns/1ps
module sat_monitor
  import sat_pkg::*;
#(
  parameter int unsigned     NUM_CH  = 8,
  parameter int unsigned     RUN_LEN = 20,
  parameter int unsigned     FILT_W  = 26,
  parameter int unsigned     OUT_W   = 24,
  parameter longint unsigned FILT_FS = 64'd8388608
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0]             mod_bit,
  input  logic [NUM_CH-1:0]             mod_vld,
  input  logic [NUM_CH*FILT_W-1:0]      filt_data,
  input  logic [NUM_CH-1:0]             filt_vld,
  input  logic [NUM_CH*OUT_W-1:0]       out_data,
  input  logic [NUM_CH-1:0]             out_vld,
  input  logic [2:0]                    det_dis,
  input  logic [NUM_CH/2-1:0]           rd_strobe,
  output logic [NUM_CH/2*BYTE_BITS-1:0] pair_regs
);
  localparam int unsigned NUM_PAIRS = NUM_CH / 2;

  // named internal events, observed by the bound checker
  logic [NUM_CH-1:0] mod_live_q,  mod_live_d;
  logic [NUM_CH-1:0] filt_live_q, filt_live_d;
  logic [NUM_CH-1:0] out_live_q,  out_live_d;
  logic [NUM_CH-1:0] flag_mod, flag_filt, flag_out;
  logic [NUM_CH-1:0] ch_rd;
  logic              en_mod, en_filt, en_out;

  assign en_mod  = ~det_dis[DIS_MOD];
  assign en_filt = ~det_dis[DIS_FILT];
  assign en_out  = ~det_dis[DIS_OUT];

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ch_rd[c] = rd_strobe[c/2];

      sat_run_det #(.RUN_LEN(RUN_LEN)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (mod_vld[c]),
        .bit_i    (mod_bit[c]),
        .live_q_o (mod_live_q[c]),
        .live_d_o (mod_live_d[c])
      );

      sat_level_det #(.W(FILT_W), .KIND(KIND_RANGE), .FS(FILT_FS)) u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (filt_vld[c]),
        .data_i   (filt_data[c*FILT_W +: FILT_W]),
        .live_q_o (filt_live_q[c]),
        .live_d_o (filt_live_d[c])
      );

      sat_level_det #(.W(OUT_W), .KIND(KIND_CLIP), .FS(FILT_FS)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_i    (out_vld[c]),
        .data_i   (out_data[c*OUT_W +: OUT_W]),
        .live_q_o (out_live_q[c]),
        .live_d_o (out_live_d[c])
      );

      sat_sticky u_flag_mod (
        .clk(clk), .rst_n(rst_n), .en_i(en_mod), .rd_i(ch_rd[c]),
        .live_d_i(mod_live_d[c]), .flag_o(flag_mod[c])
      );
      sat_sticky u_flag_filt (
        .clk(clk), .rst_n(rst_n), .en_i(en_filt), .rd_i(ch_rd[c]),
        .live_d_i(filt_live_d[c]), .flag_o(flag_filt[c])
      );
      sat_sticky u_flag_out (
        .clk(clk), .rst_n(rst_n), .en_i(en_out), .rd_i(ch_rd[c]),
        .live_d_i(out_live_d[c]), .flag_o(flag_out[c])
      );
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      for (genvar h = 0; h < 2; h++) begin : g_half
        localparam int unsigned BASE = p*BYTE_BITS + h*SLOT_BITS;
        assign pair_regs[BASE + SLOT_OUT]  = flag_out [2*p + h];
        assign pair_regs[BASE + SLOT_FILT] = flag_filt[2*p + h];
        assign pair_regs[BASE + SLOT_MOD]  = flag_mod [2*p + h];
      end
      assign pair_regs[p*BYTE_BITS + 2*SLOT_BITS +: BYTE_BITS - 2*SLOT_BITS] = '0;
    end
  endgenerate

endmodule

// File: rtl/sat_monitor_chk.sv
`timescale 1ns/1ps
module sat_monitor_chk #(
  parameter int unsigned NUM_CH = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            det_dis,
  input logic [NUM_CH/2-1:0]   rd_strobe,
  input logic [NUM_CH/2*8-1:0] pair_regs,
  input logic [NUM_CH-1:0]     mod_vld,
  input logic [NUM_CH-1:0]     filt_vld,
  input logic [NUM_CH-1:0]     out_vld,
  input logic [NUM_CH-1:0]     mod_live_q,
  input logic [NUM_CH-1:0]     filt_live_q,
  input logic [NUM_CH-1:0]     out_live_q,
  input logic [NUM_CH-1:0]     flag_mod,
  input logic [NUM_CH-1:0]     flag_filt,
  input logic [NUM_CH-1:0]     flag_out
);
  generate
    for (genvar p = 0; p < NUM_CH/2; p++) begin : g_p
      // R6: top two bits of each byte stay zero
      p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pair_regs[p*8 + 7 -: 2] == 2'b00);
      for (genvar k = 0; k < 6; k++) begin : g_k
        // R8: a set bit holds while its byte is not read
        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
          pair_regs[p*8 + k] && !rd_strobe[p] |=> pair_regs[p*8 + k]);
      end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      // R2: a run reaching terminal count raises the flag when enabled
      p_run_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_live_q[c]) && !$past(det_dis[2]) |-> flag_mod[c]);
      // R7: disabled detectors never raise their flag
      p_dis_mod_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_mod[c] && det_dis[2] |=> !flag_mod[c]);
      p_dis_filt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_filt[c] && det_dis[1] |=> !flag_filt[c]);
      p_dis_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_out[c] && det_dis[0] |=> !flag_out[c]);
      // R9: a read with the condition gone and no new sample clears the flag
      p_clear_mod_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe[c/2] && !mod_vld[c] && !mod_live_q[c] |=> !flag_mod[c]);
      p_clear_filt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe[c/2] && !filt_vld[c] && !filt_live_q[c] |=> !flag_filt[c]);
      p_clear_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe[c/2] && !out_vld[c] && !out_live_q[c] |=> !flag_out[c]);
      // R9: a still-present condition survives a read
      p_keep_filt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe[c/2] && !filt_vld[c] && filt_live_q[c] && !det_dis[1] |=> flag_filt[c]);
    end
  endgenerate
endmodule

bind sat_monitor sat_monitor_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .det_dis     (det_dis),
  .rd_strobe   (rd_strobe),
  .pair_regs   (pair_regs),
  .mod_vld     (mod_vld),
  .filt_vld    (filt_vld),
  .out_vld     (out_vld),
  .mod_live_q  (mod_live_q),
  .filt_live_q (filt_live_q),
  .out_live_q  (out_live_q),
  .flag_mod    (flag_mod),
  .flag_filt   (flag_filt),
  .flag_out    (flag_out)
);

// File: tb/sat_monitor_test.sv
`timescale 1ns/1ps
module sat_monitor_test;
  localparam int NCH = 8;
  localparam int NP  = NCH / 2;
  localparam int FW  = 26;
  localparam int OW  = 24;
  localparam int RUN = 20;
  localparam longint FS   = 64'd8388608;
  localparam longint LIM  = FS + (FS * 819) / 4096;
  localparam longint OMAX = (64'sd1 <<< (OW-1)) - 1;
  localparam longint OMIN = -(64'sd1 <<< (OW-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0]    mod_bit = '0, mod_vld = '0, filt_vld = '0, out_vld = '0;
  logic [NCH*FW-1:0] filt_data = '0;
  logic [NCH*OW-1:0] out_data = '0;
  logic [2:0]        det_dis = '0;
  logic [NP-1:0]     rd_strobe = '0;
  logic [NP*8-1:0]   pair_regs;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // requirement-level model
  int run_cnt [NCH];
  bit prev_b  [NCH];
  bit lv_m [NCH], lv_f [NCH], lv_o [NCH];
  bit e_m  [NCH], e_f  [NCH], e_o  [NCH];

  sat_monitor uut (
    .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .mod_vld(mod_vld),
    .filt_data(filt_data), .filt_vld(filt_vld), .out_data(out_data),
    .out_vld(out_vld), .det_dis(det_dis), .rd_strobe(rd_strobe),
    .pair_regs(pair_regs)
  );

  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < NP; p++) begin
      logic [7:0] exp;
      exp = {2'b00, e_m[2*p+1], e_f[2*p+1], e_o[2*p+1], e_m[2*p], e_f[2*p], e_o[2*p]};
      checks++;
      if (pair_regs[p*8 +: 8] !== exp) begin
        errors++;
        $display("FAIL %s byte %0d: actual %b expected %b", req, p, pair_regs[p*8 +: 8], exp);
      end
    end
  endtask

  task automatic send_mod(input int ch, input bit b);
    mod_bit[ch] = b; mod_vld[ch] = 1'b1;
    step();
    mod_vld[ch] = 1'b0;
    if (run_cnt[ch] > 0 && b == prev_b[ch]) run_cnt[ch] = (run_cnt[ch] >= RUN) ? RUN : run_cnt[ch] + 1;
    else run_cnt[ch] = 1;
    prev_b[ch] = b;
    lv_m[ch] = (run_cnt[ch] == RUN);
    if (lv_m[ch] && !det_dis[2]) e_m[ch] = 1;
  endtask

  task automatic send_filt(input int ch, input longint v);
    filt_data[ch*FW +: FW] = v[FW-1:0]; filt_vld[ch] = 1'b1;
    step();
    filt_vld[ch] = 1'b0;
    lv_f[ch] = (v > LIM) || (v < -LIM);
    if (lv_f[ch] && !det_dis[1]) e_f[ch] = 1;
  endtask

  task automatic send_out(input int ch, input longint v);
    out_data[ch*OW +: OW] = v[OW-1:0]; out_vld[ch] = 1'b1;
    step();
    out_vld[ch] = 1'b0;
    lv_o[ch] = (v == OMAX) || (v == OMIN);
    if (lv_o[ch] && !det_dis[0]) e_o[ch] = 1;
  endtask

  task automatic read_pair(input int p);
    rd_strobe[p] = 1'b1;
    step();
    rd_strobe[p] = 1'b0;
    for (int c = 2*p; c < 2*p+2; c++) begin
      e_m[c] = lv_m[c] && !det_dis[2];
      e_f[c] = lv_f[c] && !det_dis[1];
      e_o[c] = lv_o[c] && !det_dis[0];
    end
  endtask

  task automatic set_dis(input logic [2:0] d);
    det_dis = d;
    step();
    for (int c = 0; c < NCH; c++) begin
      if (lv_m[c] && !d[2]) e_m[c] = 1;
      if (lv_f[c] && !d[1]) e_f[c] = 1;
      if (lv_o[c] && !d[0]) e_o[c] = 1;
    end
  endtask

  task automatic quiet_all();
    for (int c = 0; c < NCH; c++) begin
      send_mod(c, ~prev_b[c]);
      send_filt(c, 0);
      send_out(c, 0);
    end
    for (int p = 0; p < NP; p++) read_pair(p);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      run_cnt[c] = 0; prev_b[c] = 0;
      lv_m[c] = 0; lv_f[c] = 0; lv_o[c] = 0;
      e_m[c] = 0; e_f[c] = 0; e_o[c] = 0;
    end
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check_all("R1 reset");

    // R2 R3 R6: every run length, both polarities, every channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int b = 0; b < 2; b++) begin
        for (int n = 1; n <= RUN + 1; n++) begin
          send_mod(ch, ~b[0]);
          read_pair(ch / 2);
          for (int i = 0; i < n; i++) begin
            send_mod(ch, b[0]);
            if (i % 3 == 1) begin
              mod_bit[ch] = ~b[0];   // strobe low: must be ignored (R2)
              step();
            end
          end
          check_all("R2 run length");
        end
      end
    end
    quiet_all();
    check_all("R9 clean after sweep");

    // R3: a break restarts the run; terminal count holds
    for (int i = 0; i < 12; i++) send_mod(5, 1'b1);
    send_mod(5, 1'b0);
    for (int i = 0; i < RUN - 1; i++) send_mod(5, 1'b1);
    check_all("R3 restart no flag");
    send_mod(5, 1'b1);
    check_all("R3 terminal flag");
    for (int i = 0; i < 5; i++) send_mod(5, 1'b1);
    read_pair(2);
    check_all("R9 stuck run survives read");
    send_mod(5, 1'b0);
    check_all("R8 sticky after run ends");
    read_pair(2);
    check_all("R9 cleared after run ends");

    // R4: filter limit boundaries on every channel
    for (int ch = 0; ch < NCH; ch++) begin
      longint vals [8];
      vals = '{0, LIM, LIM + 1, -LIM, -LIM - 1, FS, (64'sd1 <<< (FW-1)) - 1, -(64'sd1 <<< (FW-1))};
      foreach (vals[k]) begin
        send_filt(ch, 0);
        read_pair(ch / 2);
        send_filt(ch, vals[k]);
        check_all("R4 filter limit");
      end
      read_pair(ch / 2);
      check_all("R9 filter still over survives read");
      send_filt(ch, 0);
      check_all("R8 filter sticky");
      read_pair(ch / 2);
      check_all("R9 filter cleared");
    end

    // R5: output rail codes and neighbours
    for (int ch = 0; ch < NCH; ch++) begin
      longint ovals [7];
      ovals = '{OMAX, OMIN, OMAX - 1, OMIN + 1, 0, 1, -1};
      foreach (ovals[k]) begin
        send_out(ch, 0);
        read_pair(ch / 2);
        send_out(ch, ovals[k]);
        check_all("R5 output clip");
      end
      send_out(ch, 0);
      read_pair(ch / 2);
    end
    check_all("R9 output cleared");

    // R7: each disable bit alone, with all three conditions live on channel 3
    for (int k = 0; k < 3; k++) begin
      set_dis(3'(1 << k));
      for (int i = 0; i < RUN; i++) send_mod(3, 1'b0);
      send_filt(3, LIM + 5);
      send_out(3, OMIN);
      check_all("R7 disabled type stays clear");
      set_dis(3'b000);
      check_all("R7 re-enable with live condition");
      quiet_all();
    end
    check_all("R7 clean");

    // R10: read of one byte leaves another untouched
    send_filt(1, -LIM - 100);
    check_all("R10 one-cycle latency");
    send_out(6, OMAX);
    send_filt(1, 0);
    send_out(6, 0);
    read_pair(0);
    check_all("R10 byte isolation");
    read_pair(3);
    check_all("R10 second byte cleared");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule